// File: doc/BRIEF.md
# Quadrature Position Counter Core

This block turns the four already-filtered encoder lines (phase A, phase B, index and home) into a signed-agnostic 32-bit position count and a 16-bit revolution count. Its normal decode is four-times quadrature. A single-phase mode takes each rising edge of phase A as one count and reads phase B as the direction. The counter can wrap inside a programmed window. It can be reloaded from an initial value by software, by an index edge or by a home edge, and the edge polarity of each line is selectable. Inputs are assumed to be already synchronised to `clk`.

Software uses one word-addressed port. With `wr_en` high, `addr` selects the register that is written. With `wr_en` low, `addr` selects the register shown on `rd_data`, which is combinational. Seven sticky event flags are cleared by writing ones to them. Each flag is gated by its own enable bit, and the gated flags are ORed onto `irq`. Register addresses: 0 config, 1 flag enables, 2 flags, 3 position, 4 revolution, 5 initial value, 6 modulus, 7 compare, 8 watchdog limit, 9 status.

Top module: `qpc_core`

## Requirements
- R1: In quadrature mode the (A,B) sequence 00→10→11→01→00 counts up by one per transition, and the reverse sequence counts down. Position at address 3 reflects an input sample after one clock edge. Without a count, initialisation or write, the position holds.
- R2: Config bit 1 (reverse) inverts the counting direction in quadrature mode.
- R3: With config bit 0 set (single-phase), only a rising edge of A counts. The count goes up when B XOR reverse is 0 and down when it is 1.
- R4: In quadrature mode, a sample where A and B both change leaves the position unchanged and sets flag bit 6.
- R5: The position is loaded from the initial value (address 5) in three cases: a config write with bit 9 set; a selected index edge when config bit 4 is set; a selected home edge when config bit 6 is set. Config bit 5 selects the falling index edge and config bit 7 the falling home edge (0 selects rising). A selected index edge sets flag bit 2 and a selected home edge sets flag bit 3. A register write to the position takes priority over every load.
- R6: With config bit 2 set, counting up from the modulus (address 6) gives the initial value and sets flag bit 4. Counting down from the initial value gives the modulus and sets flag bit 5. Without modulo, stepping up from all-ones to zero sets bit 4 and stepping down from zero to all-ones sets bit 5.
- R7: With config bit 3 set, bit-4 and bit-5 wrap events add one to or subtract one from the revolution count. Otherwise a selected index edge adds one if the last step was up and subtracts one if it was down. A write to address 4 takes priority.
- R8: Status bit 0 is 1 after an up step and 0 after a down step. It is 0 out of reset.
- R9: With config bit 8 set and limit T, flag bit 1 is set after T+1 consecutive clock edges without a count step. Every step restarts the window.
- R10: When the position becomes equal to the compare value (address 7), `posmatch` is high for exactly one cycle and flag bit 0 is set.
- R11: Writing a 1 to a bit of address 2 clears that flag unless it is set again in the same cycle. `irq` is high exactly when some flag and its enable (address 1, same bit position) are both set.
- R12: After reset, position, revolution count, flags, status, `posmatch` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed register |
| ph_a | input | 1 | Filtered phase A |
| ph_b | input | 1 | Filtered phase B |
| index_in | input | 1 | Filtered index line |
| home_in | input | 1 | Filtered home line |
| posmatch | output | 1 | One-cycle pulse when the position reaches the compare value |
| irq | output | 1 | OR of enabled sticky flags |

## Verification
The decoder is exercised in five ways:
- forward and backward Gray sequences, which separate the up and down table entries;
- the same sequences with the reverse bit set, which shows the inversion happens after decode;
- a two-line jump, which must set the simultaneous-change flag and leave the count alone;
- single-phase pulses with B low and high, with and without reverse, which must count only on the rising edges of A;
- index and home pulses under both polarities, which show that loads happen on the chosen edge and not the other one.

Modulo windows are crossed in both directions with the revolution count tied to wraps, and the natural 32-bit wrap is crossed too. These runs separate wraps that flag from wraps that do not.

// File: rtl/qpc_pkg.sv
`timescale 1ns/1ps
// Shared constants for the quadrature position counter: register
// addresses, flag bit positions and the packed configuration word.
package qpc_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CFG     = 4'd0;
    localparam logic [ADDR_W-1:0] A_IRQEN   = 4'd1;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 4'd2;
    localparam logic [ADDR_W-1:0] A_POS     = 4'd3;
    localparam logic [ADDR_W-1:0] A_REV     = 4'd4;
    localparam logic [ADDR_W-1:0] A_INIT    = 4'd5;
    localparam logic [ADDR_W-1:0] A_MODULUS = 4'd6;
    localparam logic [ADDR_W-1:0] A_COMPARE = 4'd7;
    localparam logic [ADDR_W-1:0] A_WDLIM   = 4'd8;
    localparam logic [ADDR_W-1:0] A_STATUS  = 4'd9;

    localparam int NFLAG    = 7;
    localparam int F_CMP    = 0;
    localparam int F_WDT    = 1;
    localparam int F_IDX    = 2;
    localparam int F_HOME   = 3;
    localparam int F_ROVER  = 4;
    localparam int F_RUNDER = 5;
    localparam int F_SIMUL  = 6;

    localparam int CFG_W      = 9;
    localparam int SWINIT_BIT = 9;

    // Bit 0 is the last member.
    typedef struct packed {
        logic wdt_en;     // 8
        logic home_fall;  // 7
        logic home_init;  // 6
        logic idx_fall;   // 5
        logic idx_init;   // 4
        logic rev_mod;    // 3
        logic modulo;     // 2
        logic reverse;    // 1
        logic single;     // 0
    } cfg_t;
endpackage

// File: rtl/qpc_phase_dec.sv
`timescale 1ns/1ps
// Phase and edge decoder.
// Holds the previous sample of all four input lines and compares it
// with the present sample. It produces a count step with its direction,
// a flag for a simultaneous A/B change, and the polarity-selected
// index and home edge events.
// Assumes the inputs are synchronous to clk and already de-glitched.
module qpc_phase_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic ph_a,
    input  logic ph_b,
    input  logic index_in,
    input  logic home_in,
    input  logic single,
    input  logic reverse,
    input  logic idx_fall,
    input  logic home_fall,
    output logic step,
    output logic step_up,
    output logic simul,
    output logic idx_evt,
    output logic home_evt
);
    logic       a_q, b_q;
    logic [1:0] lvl, lvl_q, pol, evt;
    logic [1:0] prev_ph, cur_ph, delta;
    logic       raw_up;

    // Previous-sample registers for all four lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= 1'b0;
            b_q   <= 1'b0;
            lvl_q <= 2'b00;
        end else begin
            a_q   <= ph_a;
            b_q   <= ph_b;
            lvl_q <= lvl;
        end
    end

    // Gray position of the (A,B) pair: 00->0, 10->1, 11->2, 01->3.
    assign prev_ph = {b_q, a_q ^ b_q};
    assign cur_ph  = {ph_b, ph_a ^ ph_b};
    assign delta   = cur_ph - prev_ph;

    // Step and raw direction for the selected decode mode.
    always_comb begin
        step   = 1'b0;
        raw_up = 1'b0;
        simul  = 1'b0;
        if (single) begin
            step   = ph_a & ~a_q;
            raw_up = ~ph_b;
        end else begin
            case (delta)
                2'd1:    begin step = 1'b1; raw_up = 1'b1; end
                2'd3:    begin step = 1'b1; raw_up = 1'b0; end
                2'd2:    simul = 1'b1;
                default: ;
            endcase
        end
    end

    assign step_up = raw_up ^ reverse;

    // Index (bit 0) and home (bit 1) edge events with selectable polarity.
    assign lvl = {home_in, index_in};
    assign pol = {home_fall, idx_fall};
    for (genvar k = 0; k < 2; k++) begin : g_edge
        assign evt[k] = pol[k] ? (~lvl[k] & lvl_q[k]) : (lvl[k] & ~lvl_q[k]);
    end
    assign idx_evt  = evt[0];
    assign home_evt = evt[1];
endmodule

// File: rtl/qpc_pos_cnt.sv
`timescale 1ns/1ps
// Position counter.
// Priority: register write, then initial-value load, then count step.
// In modulo mode the count wraps between the initial value and the
// modulus. Without modulo it wraps at the natural width. Wrap events
// are flagged only when a step actually moves the counter.
module qpc_pos_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_wr,
    input  logic [W-1:0] wr_val,
    input  logic         load_init,
    input  logic [W-1:0] init_val,
    input  logic [W-1:0] modulus,
    input  logic         modulo_en,
    input  logic         step,
    input  logic         step_up,
    output logic [W-1:0] pos,
    output logic         roll_over,
    output logic         roll_under
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] nxt;

    // Next-value selection with wrap detection.
    always_comb begin
        nxt        = pos;
        roll_over  = 1'b0;
        roll_under = 1'b0;
        if (load_wr) begin
            nxt = wr_val;
        end else if (load_init) begin
            nxt = init_val;
        end else if (step) begin
            if (step_up) begin
                if (modulo_en && pos == modulus) begin
                    nxt       = init_val;
                    roll_over = 1'b1;
                end else begin
                    nxt       = pos + ONE;
                    roll_over = !modulo_en && (pos == '1);
                end
            end else begin
                if (modulo_en && pos == init_val) begin
                    nxt        = modulus;
                    roll_under = 1'b1;
                end else begin
                    nxt        = pos - ONE;
                    roll_under = !modulo_en && (pos == '0);
                end
            end
        end
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pos <= '0;
        else        pos <= nxt;
    end
endmodule

// File: rtl/qpc_wdog.sv
`timescale 1ns/1ps
// No-motion watchdog.
// While enabled, counts clock edges that carry no step. Once limit+1
// such edges have passed, it raises a one-cycle timeout and starts over.
// A step, or enable being low, holds the count at zero.
module qpc_wdog #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         timeout
);
    assign timeout = enable && !restart && (count == limit);

    // Idle-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                            count <= '0;
        else if (!enable || restart || timeout) count <= '0;
        else                                   count <= count + W'(1);
    end
endmodule

// File: rtl/qpc_core.sv
`timescale 1ns/1ps
// Quadrature position counter core (top).
// Holds the configuration and value registers, the revolution counter,
// the direction bit, the compare logic and the sticky flags. Decoding,
// position counting and the watchdog are delegated to submodules.
// Assumes DATA_W is no smaller than POS_W, REV_W and WDT_W.
module qpc_core
    import qpc_pkg::*;
#(
    parameter int POS_W  = 32,
    parameter int REV_W  = 16,
    parameter int WDT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ph_a,
    input  logic              ph_b,
    input  logic              index_in,
    input  logic              home_in,
    output logic              posmatch,
    output logic              irq
);
    localparam logic [REV_W-1:0] REV_ONE = REV_W'(1);

    cfg_t             cfg_q;
    logic [CFG_W-1:0] cfg_bits;
    logic [NFLAG-1:0] irq_en_q, flags_q, flag_set;
    logic [POS_W-1:0] pos_q, init_q, mod_q, cmp_q;
    logic [REV_W-1:0] rev_q;
    logic [WDT_W-1:0] wdt_lim_q, wd_cnt;
    logic             dir_q, match_q, match_now;
    logic             step, step_up, simul, idx_evt, home_evt;
    logic             roll_over, roll_under, wdt_timeout;
    logic             swinit, init_any, pos_wr, rev_wr, flags_wr;

    assign cfg_bits = cfg_q;
    assign pos_wr   = wr_en && addr == A_POS;
    assign rev_wr   = wr_en && addr == A_REV;
    assign flags_wr = wr_en && addr == A_FLAGS;
    assign swinit   = wr_en && addr == A_CFG && wr_data[SWINIT_BIT];
    assign init_any = swinit || (idx_evt && cfg_q.idx_init) || (home_evt && cfg_q.home_init);

    qpc_phase_dec u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph_a     (ph_a),
        .ph_b     (ph_b),
        .index_in (index_in),
        .home_in  (home_in),
        .single   (cfg_q.single),
        .reverse  (cfg_q.reverse),
        .idx_fall (cfg_q.idx_fall),
        .home_fall(cfg_q.home_fall),
        .step     (step),
        .step_up  (step_up),
        .simul    (simul),
        .idx_evt  (idx_evt),
        .home_evt (home_evt)
    );

    qpc_pos_cnt #(.W(POS_W)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_wr   (pos_wr),
        .wr_val    (wr_data[POS_W-1:0]),
        .load_init (init_any),
        .init_val  (init_q),
        .modulus   (mod_q),
        .modulo_en (cfg_q.modulo),
        .step      (step),
        .step_up   (step_up),
        .pos       (pos_q),
        .roll_over (roll_over),
        .roll_under(roll_under)
    );

    qpc_wdog #(.W(WDT_W)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (cfg_q.wdt_en),
        .restart(step),
        .limit  (wdt_lim_q),
        .count  (wd_cnt),
        .timeout(wdt_timeout)
    );

    // Software-written configuration and value registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            irq_en_q  <= '0;
            init_q    <= '0;
            mod_q     <= '0;
            cmp_q     <= '0;
            wdt_lim_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CFG:     cfg_q     <= cfg_t'(wr_data[CFG_W-1:0]);
                A_IRQEN:   irq_en_q  <= wr_data[NFLAG-1:0];
                A_INIT:    init_q    <= wr_data[POS_W-1:0];
                A_MODULUS: mod_q     <= wr_data[POS_W-1:0];
                A_COMPARE: cmp_q     <= wr_data[POS_W-1:0];
                A_WDLIM:   wdt_lim_q <= wr_data[WDT_W-1:0];
                default:   ;
            endcase
        end
    end

    // Revolution counter: wrap-driven or index-driven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rev_q <= '0;
        end else if (rev_wr) begin
            rev_q <= wr_data[REV_W-1:0];
        end else if (cfg_q.rev_mod) begin
            if (roll_over)       rev_q <= rev_q + REV_ONE;
            else if (roll_under) rev_q <= rev_q - REV_ONE;
        end else if (idx_evt) begin
            rev_q <= dir_q ? rev_q + REV_ONE : rev_q - REV_ONE;
        end
    end

    // Direction of the most recent step.
    always_ff @(posedge clk) begin
        if (!rst_n)    dir_q <= 1'b0;
        else if (step) dir_q <= step_up;
    end

    // Compare: pulse on arrival at the compare value.
    assign match_now = (pos_q == cmp_q);
    assign posmatch  = match_now && !match_q;
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b1;
        else        match_q <= match_now;
    end

    // Sticky flags, set has priority over write-one-to-clear.
    assign flag_set[F_CMP]    = posmatch;
    assign flag_set[F_WDT]    = wdt_timeout;
    assign flag_set[F_IDX]    = idx_evt;
    assign flag_set[F_HOME]   = home_evt;
    assign flag_set[F_ROVER]  = roll_over;
    assign flag_set[F_RUNDER] = roll_under;
    assign flag_set[F_SIMUL]  = simul;

    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        // One sticky flag bit.
        always_ff @(posedge clk) begin
            if (!rst_n)                       flags_q[k] <= 1'b0;
            else if (flag_set[k])             flags_q[k] <= 1'b1;
            else if (flags_wr && wr_data[k])  flags_q[k] <= 1'b0;
        end
    end

    assign irq = |(flags_q & irq_en_q);

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_CFG:     rd_data = DATA_W'(cfg_bits);
            A_IRQEN:   rd_data = DATA_W'(irq_en_q);
            A_FLAGS:   rd_data = DATA_W'(flags_q);
            A_POS:     rd_data = DATA_W'(pos_q);
            A_REV:     rd_data = DATA_W'(rev_q);
            A_INIT:    rd_data = DATA_W'(init_q);
            A_MODULUS: rd_data = DATA_W'(mod_q);
            A_COMPARE: rd_data = DATA_W'(cmp_q);
            A_WDLIM:   rd_data = DATA_W'(wdt_lim_q);
            A_STATUS:  rd_data = DATA_W'(dir_q);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/qpc_core_chk.sv
`timescale 1ns/1ps
// Assertion checker for qpc_core, attached by bind below.
module qpc_core_chk
    import qpc_pkg::*;
#(
    parameter int POS_W = 32,
    parameter int REV_W = 16,
    parameter int WDT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [POS_W-1:0] pos,
    input logic [POS_W-1:0] init_val,
    input logic [REV_W-1:0] rev,
    input logic [NFLAG-1:0] flags,
    input logic             step,
    input logic             step_up,
    input logic             simul,
    input logic             init_any,
    input logic             pos_wr,
    input logic             rev_wr,
    input logic             modulo_en,
    input logic             rev_mod,
    input logic             roll_over,
    input logic             roll_under,
    input logic             posmatch,
    input logic             irq,
    input logic             dir,
    input logic [WDT_W-1:0] wd_cnt,
    input logic             wdt_timeout
);
    localparam logic [POS_W-1:0] P1 = POS_W'(1);
    localparam logic [REV_W-1:0] R1V = REV_W'(1);

    // R1
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !init_any && !pos_wr) |=> $stable(pos));
    // R1
    count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && step_up && !init_any && !pos_wr && !roll_over) |=> pos == $past(pos) + P1);
    // R1
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !step_up && !init_any && !pos_wr && !roll_under) |=> pos == $past(pos) - P1);
    // R4
    simul_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (simul && !init_any && !pos_wr) |=> $stable(pos) && flags[F_SIMUL]);
    // R5
    init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_any && !pos_wr) |=> pos == $past(init_val));
    // R6
    mod_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (modulo_en && roll_over) |=> pos == $past(init_val));
    // R6
    roll_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_over || roll_under) |=> (flags[F_ROVER] || flags[F_RUNDER]));
    // R7
    rev_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_mod && roll_over && !rev_wr) |=> rev == $past(rev) + R1V);
    // R8
    dir_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> dir == $past(step_up));
    // R9
    wdog_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> wd_cnt == '0);
    // R9
    wdog_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |=> flags[F_WDT]);
    // R10
    posmatch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        posmatch |=> !posmatch && flags[F_CMP]);
    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq);
endmodule

bind qpc_core qpc_core_chk #(.POS_W(POS_W), .REV_W(REV_W), .WDT_W(WDT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pos        (pos_q),
    .init_val   (init_q),
    .rev        (rev_q),
    .flags      (flags_q),
    .step       (step),
    .step_up    (step_up),
    .simul      (simul),
    .init_any   (init_any),
    .pos_wr     (pos_wr),
    .rev_wr     (rev_wr),
    .modulo_en  (cfg_q.modulo),
    .rev_mod    (cfg_q.rev_mod),
    .roll_over  (roll_over),
    .roll_under (roll_under),
    .posmatch   (posmatch),
    .irq        (irq),
    .dir        (dir_q),
    .wd_cnt     (wd_cnt),
    .wdt_timeout(wdt_timeout)
);

// File: tb/qpc_core_test.sv
`timescale 1ns/1ps
// Bench for qpc_core: a behavioural reference model advanced once per
// clock, compared against the outputs and the readable registers.
module qpc_core_test;
    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wr_data = 32'd0, rd_data;
    logic        ph_a = 1'b0, ph_b = 1'b0, idx = 1'b0, home = 1'b0;
    logic        posmatch, irq;

    always #4 clk = ~clk;

    qpc_core uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .ph_a(ph_a), .ph_b(ph_b), .index_in(idx),
        .home_in(home), .posmatch(posmatch), .irq(irq)
    );

    int    vectors = 0, miscompares = 0;
    string cur_req = "R12";
    int    g = 0;

    // Model state
    logic [31:0] m_pos = 0, m_init = 0, m_mod = 0, m_cmp = 0;
    logic [15:0] m_rev = 0, m_lim = 0;
    logic [8:0]  m_cfg = 0;
    logic [6:0]  m_en = 0, m_flags = 0;
    logic        m_dir = 0, m_mq = 1, m_aq = 0, m_bq = 0, m_iq = 0, m_hq = 0;
    int          m_wd = 0;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // Advance the model by one clock edge using the present inputs.
    task automatic model_edge();
        bit stp = 0, up = 0, sim = 0, iev, hev, ini, ro = 0, ru = 0, pm, tmo = 0;
        int pi, ci, d;
        logic [31:0] np;
        logic [6:0]  clr;
        if (m_cfg[0]) begin
            stp = ph_a && !m_aq;
            up  = (ph_b ^ m_cfg[1]) == 1'b0;
        end else begin
            pi = m_bq * 2 + (m_aq ^ m_bq);
            ci = ph_b * 2 + (ph_a ^ ph_b);
            d  = (ci - pi + 4) % 4;
            if (d == 1)      begin stp = 1; up = !m_cfg[1]; end
            else if (d == 3) begin stp = 1; up = m_cfg[1]; end
            else if (d == 2) sim = 1;
        end
        iev = m_cfg[5] ? (!idx && m_iq) : (idx && !m_iq);
        hev = m_cfg[7] ? (!home && m_hq) : (home && !m_hq);
        ini = (wr_en && addr == 0 && wr_data[9]) || (iev && m_cfg[4]) || (hev && m_cfg[6]);
        pm  = (m_pos == m_cmp) && !m_mq;
        m_mq = (m_pos == m_cmp);
        if (!m_cfg[8] || stp) m_wd = 0;
        else if (m_wd == int'(m_lim)) begin m_wd = 0; tmo = 1; end
        else m_wd++;
        if (wr_en && addr == 3) np = wr_data;
        else if (ini) np = m_init;
        else if (stp && up) begin
            if (m_cfg[2] && m_pos == m_mod) begin np = m_init; ro = 1; end
            else begin np = m_pos + 1; ro = !m_cfg[2] && m_pos == 32'hFFFF_FFFF; end
        end else if (stp) begin
            if (m_cfg[2] && m_pos == m_init) begin np = m_mod; ru = 1; end
            else begin np = m_pos - 1; ru = !m_cfg[2] && m_pos == 0; end
        end else np = m_pos;
        if (wr_en && addr == 4) m_rev = wr_data[15:0];
        else if (m_cfg[3]) begin
            if (ro) m_rev = m_rev + 1;
            else if (ru) m_rev = m_rev - 1;
        end else if (iev) m_rev = m_dir ? m_rev + 1 : m_rev - 1;
        if (stp) m_dir = up;
        m_pos = np;
        clr = (wr_en && addr == 2) ? wr_data[6:0] : 7'd0;
        m_flags = (m_flags & ~clr) | {sim, ru, ro, hev, iev, tmo, pm};
        if (wr_en) case (addr)
            4'd0: m_cfg  = wr_data[8:0];
            4'd1: m_en   = wr_data[6:0];
            4'd5: m_init = wr_data;
            4'd6: m_mod  = wr_data;
            4'd7: m_cmp  = wr_data;
            4'd8: m_lim  = wr_data[15:0];
            default: ;
        endcase
        m_aq = ph_a; m_bq = ph_b; m_iq = idx; m_hq = home;
    endtask

    task automatic compare_all();
        chk("posmatch R10", 32'(posmatch), 32'((m_pos == m_cmp) && !m_mq));
        chk("irq R11", 32'(irq), 32'(|(m_flags & m_en)));
        addr = 4'd3; #0.2; chk("pos", rd_data, m_pos);
        addr = 4'd4; #0.2; chk("rev", rd_data, 32'(m_rev));
        addr = 4'd2; #0.2; chk("flags", rd_data, 32'(m_flags));
        addr = 4'd9; #0.2; chk("status R8", rd_data, 32'(m_dir));
    endtask

    task automatic cycle();
        model_edge();
        @(posedge clk); #1;
        wr_en = 1'b0;
        compare_all();
    endtask

    task automatic wr(int a, logic [31:0] d);
        addr = 4'(a); wr_data = d; wr_en = 1'b1;
        cycle();
    endtask

    task automatic qstep(int dir);
        g = (g + dir + 4) % 4;
        ph_a = (g == 1 || g == 2);
        ph_b = (g == 2 || g == 3);
        cycle();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic pulse_idx();
        idx = 1'b1; cycle(); idx = 1'b0; cycle();
    endtask

    task automatic pulse_home();
        home = 1'b1; cycle(); home = 1'b0; cycle();
    endtask

    initial begin
        #800000;
        miscompares++; vectors++;
        $display("FAIL %s watchdog: actual hung expected finish", cur_req);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1; rst_n = 1'b1;
        // R12: reset state
        cur_req = "R12"; compare_all();
        // R1: forward and backward Gray sequences
        cur_req = "R1";
        for (int i = 0; i < 12; i++) qstep(1);
        for (int i = 0; i < 5; i++) qstep(-1);
        idle(2);
        // R2: reverse direction in quadrature mode
        cur_req = "R2";
        wr(0, 32'h002);
        for (int i = 0; i < 4; i++) qstep(1);
        qstep(-1);
        wr(0, 32'h000);
        // R8: direction flag after up then down
        cur_req = "R8";
        qstep(1); idle(1); qstep(-1); idle(1);
        // R4: simultaneous change
        cur_req = "R4";
        g = (g + 2) % 4; ph_a = (g == 1 || g == 2); ph_b = (g == 2 || g == 3); cycle();
        qstep(1);
        // R3: single-phase mode
        cur_req = "R3";
        wr(0, 32'h001);
        ph_a = 0; ph_b = 0; cycle();
        for (int i = 0; i < 3; i++) begin ph_a = 1; cycle(); ph_a = 0; cycle(); end
        ph_b = 1;
        for (int i = 0; i < 2; i++) begin ph_a = 1; cycle(); ph_a = 0; cycle(); end
        wr(0, 32'h003);
        for (int i = 0; i < 2; i++) begin ph_a = 1; cycle(); ph_a = 0; cycle(); end
        ph_b = 0; ph_a = 1; cycle(); ph_a = 0; cycle();
        ph_a = 0; ph_b = 0; cycle(); g = 0;
        wr(0, 32'h000);
        // R5: software, index and home initialisation
        cur_req = "R5";
        wr(5, 32'd100);
        wr(0, 32'h200);
        qstep(1); qstep(1);
        wr(0, 32'h010);
        pulse_idx(); qstep(1);
        wr(0, 32'h030);
        pulse_idx(); qstep(1);
        wr(0, 32'h040);
        pulse_home(); qstep(-1);
        wr(0, 32'h0C0);
        pulse_home();
        addr = 3; wr_data = 32'd7; wr_en = 1; idx = 1;
        wr(0, 32'h010);
        addr = 3; wr_data = 32'd55; wr_en = 1; idx = 1; cycle(); idx = 0; cycle();
        wr(0, 32'h000);
        // R6: modulo window with revolution from wraps (R7)
        cur_req = "R6";
        wr(5, 32'd10); wr(6, 32'd13); wr(0, 32'h00C); wr(3, 32'd10);
        for (int i = 0; i < 6; i++) qstep(1);
        for (int i = 0; i < 8; i++) qstep(-1);
        wr(0, 32'h000);
        wr(3, 32'hFFFF_FFFF); qstep(1); qstep(-1); qstep(1);
        // R7: index-driven revolution count
        cur_req = "R7";
        wr(4, 32'd20);
        qstep(1); pulse_idx(); pulse_idx();
        qstep(-1); pulse_idx();
        wr(0, 32'h008); pulse_idx();
        wr(0, 32'h000);
        // R9: no-motion watchdog
        cur_req = "R9";
        wr(8, 32'd5); wr(2, 32'h7F); wr(0, 32'h100);
        idle(4); qstep(1); idle(12);
        wr(8, 32'd0); idle(3);
        wr(0, 32'h000);
        // R10: compare match
        cur_req = "R10";
        wr(2, 32'h7F);
        wr(7, m_pos + 32'd3);
        for (int i = 0; i < 5; i++) qstep(1);
        for (int i = 0; i < 3; i++) qstep(-1);
        // R11: enables and write-one-to-clear
        cur_req = "R11";
        wr(1, 32'h01); idle(1);
        wr(2, 32'h01); idle(1);
        wr(1, 32'h7F); qstep(1);
        wr(2, 32'h3E); idle(1);
        wr(2, 32'h7F); idle(1);
        wr(1, 32'h00); idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule